// File: doc/BRIEF.md
# Programmable Symmetric Clock Divider

This block turns a fast clock into a slower periodic level and a matching one-cycle enable, dividing by an integer ratio given on an input port. It does not create a new clock domain. Logic downstream either samples the divided level or uses the tick as a clock enable in the fast domain. Internally a binary counter is cut short so that it returns to zero after the wanted number of states. The output is always taken from a register, so a wrap can never show a short spurious pulse.

Two shaping modes are offered. In direct mode the output is the most significant active bit of the truncated count. In balanced mode an even ratio is built as a count modulo half the ratio, followed by a toggle stage, which gives an exact half-high, half-low wave. An odd ratio in balanced mode takes the count bit whose single high run comes closest to half the period. A new ratio or mode is picked up only at the end of the output period in progress. A ratio of 0 or 1 parks the block.

Top module: `clk_enable_divider`

## Requirements
- R1: While reset is high at a rising clock edge, the next cycle shows count 0, divided level 0 and tick 0.
- R2: With an active ratio N of at least 2, the count starts at 0 and steps by one each cycle. It returns to 0 after reaching M-1, where M is N/2 for an even N in balanced mode and N in every other case.
- R3: With N of at least 2, the divided level repeats with a period of exactly N cycles, is low in the first cycle of every period, and rises exactly once per period.
- R4: In balanced mode (mode input 1) with even N, the level is low for N/2 cycles and then high for N/2 cycles.
- R5: In balanced mode with odd N, the level equals count bit b, with state index p running 0..N-1. Bit b is chosen among the bits with 2^b < N <= 3*2^b, whose high time is h = min(N, 2^(b+1)) - 2^b. The choice minimises |N - 2h|, and a tie goes to the lower bit.
- R6: In direct mode (mode input 0), the level equals bit floor(log2(N-1)) of the count, with the count running 0..N-1.
- R7: The tick is high for exactly one cycle, namely the first cycle in which the divided level is high after being low, and at no other time.
- R8: A ratio of 0 or 1 holds the count at 0 and the level and tick low. A nonzero ratio of at least 2 applied while parked starts counting from state 0 one cycle later.
- R9: A change of ratio or mode while running takes effect only after the last cycle of the current output period. The following period starts at state 0 with the level low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| divRatio | input | W | Requested divide ratio N |
| balancedMode | input | 1 | 1 = balanced shaping, 0 = direct shaping |
| divClk | output | 1 | Registered divided level |
| riseTick | output | 1 | One-cycle pulse on each rising divided level |
| count | output | W | Current counter state |

## Verification
After reset is released, the first clock edge loads the configuration and the next cycle is state 0. From then on, count, level and tick are all registered and are due in the same cycle as the state they belong to. A change applied in one cycle shows at the first multiple of the old period after it, or one cycle later when the block was parked. The bench sweeps every ratio from 0 to 20 in both modes plus several mid-period changes. It works out the phase of each cycle arithmetically from that schedule and samples on the falling edge, where every registered result of the preceding rising edge has settled.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  typedef enum logic {
    MODE_DIRECT   = 1'b0,
    MODE_BALANCED = 1'b1
  } divMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic run;          // an active ratio >= 2 is loaded
    logic wrap;         // counter is at its terminal state this cycle
    logic toggleStage;  // level is driven by the half-rate toggle
  } divStrobe_t;

endpackage

// File: rtl/clkdiv_tap_select.sv
module clkdiv_tap_select #(
  parameter int W = 8
) (
  input  logic [W-1:0]         ratio,
  input  logic                 balanced,
  output logic [$clog2(W)-1:0] tapIdx
);
  localparam int IW = $clog2(W);
  localparam int SW = W + 3;

  logic [W-1:0]  bitOk;
  logic [SW-1:0] dev [W];
  logic [SW-1:0] ext;
  logic [W-1:0]  ratioM1;

  assign ext     = SW'(ratio);
  assign ratioM1 = ratio - W'(1);

  // one candidate per count bit: single high run and its imbalance
  generate
    for (genvar b = 0; b < W; b++) begin : g_cand
      localparam logic [SW-1:0] LO = SW'(1) << b;
      logic [SW-1:0] topEnd;
      logic [SW-1:0] hiCnt;
      logic [SW-1:0] twoHi;
      assign topEnd   = (ext < (LO << 1)) ? ext : (LO << 1);
      assign hiCnt    = topEnd - LO;
      assign twoHi    = hiCnt << 1;
      assign bitOk[b] = (ext > LO) && (ext <= (LO + (LO << 1)));
      assign dev[b]   = (ext >= twoHi) ? (ext - twoHi) : (twoHi - ext);
    end
  endgenerate

  logic [IW-1:0] bestIdx;
  logic [SW-1:0] bestDev;
  logic          found;
  logic [IW-1:0] msbIdx;

  always_comb begin
    bestIdx = '0;
    bestDev = '1;
    found   = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (bitOk[i] && (!found || dev[i] < bestDev)) begin
        found   = 1'b1;
        bestDev = dev[i];
        bestIdx = IW'(i);
      end
    end
  end

  always_comb begin
    msbIdx = '0;
    for (int i = 0; i < W; i++) begin
      if (ratioM1[i]) msbIdx = IW'(i);
    end
  end

  assign tapIdx = balanced ? bestIdx : msbIdx;

endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [W-1:0]         divRatio,
  input  logic                 modeSel,
  input  logic [W-1:0]         count,
  input  logic                 divClk,
  output divStrobe_t           strobe,
  output logic [$clog2(W)-1:0] tapIdx
);
  localparam int IW = $clog2(W);

  logic          cfgRun;
  logic          cfgToggle;
  logic [W-1:0]  cfgTerm;
  logic [IW-1:0] cfgTap;

  logic          nRun;
  logic          nToggle;
  logic [W-1:0]  nTerm;
  logic [IW-1:0] nTap;
  logic          wantBalanced;
  logic          wrapNow;
  logic          reload;

  assign wantBalanced = (divMode_e'(modeSel) == MODE_BALANCED);
  assign nRun    = (divRatio >= W'(2));
  assign nToggle = wantBalanced && !divRatio[0];
  assign nTerm   = nToggle ? ((divRatio >> 1) - W'(1)) : (divRatio - W'(1));

  clkdiv_tap_select #(.W(W)) u_tap (
    .ratio    (divRatio),
    .balanced (wantBalanced),
    .tapIdx   (nTap)
  );

  // a period ends at the wrap; with the toggle stage only at the wrap
  // that brings the level back low
  assign wrapNow = cfgRun && (count == cfgTerm);
  assign reload  = !cfgRun || (wrapNow && (!cfgToggle || divClk));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgRun    <= 1'b0;
      cfgToggle <= 1'b0;
      cfgTerm   <= '0;
      cfgTap    <= '0;
    end else if (reload) begin
      cfgRun    <= nRun;
      cfgToggle <= nToggle;
      cfgTerm   <= nTerm;
      cfgTap    <= nTap;
    end
  end

  assign strobe.run         = cfgRun;
  assign strobe.wrap        = wrapNow;
  assign strobe.toggleStage = cfgToggle;
  assign tapIdx             = cfgTap;

endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  divStrobe_t           strobe,
  input  logic [$clog2(W)-1:0] tapIdx,
  output logic [W-1:0]         count,
  output logic                 divClk,
  output logic                 riseTick
);
  logic [W-1:0] stepCount;
  logic         nextLevel;

  assign stepCount = strobe.wrap ? '0 : (count + W'(1));
  assign nextLevel = strobe.toggleStage ? (divClk ^ strobe.wrap)
                                        : stepCount[tapIdx];

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      divClk   <= 1'b0;
      riseTick <= 1'b0;
    end else if (!strobe.run) begin
      count    <= '0;
      divClk   <= 1'b0;
      riseTick <= 1'b0;
    end else begin
      count    <= stepCount;
      divClk   <= nextLevel;
      riseTick <= nextLevel && !divClk;
    end
  end

endmodule

// File: rtl/clk_enable_divider.sv
module clk_enable_divider
  import clkdiv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] divRatio,
  input  logic         balancedMode,
  output logic         divClk,
  output logic         riseTick,
  output logic [W-1:0] count
);
  localparam int IW = $clog2(W);

  divStrobe_t    strobe;
  logic [IW-1:0] tapIdx;

  clkdiv_ctrl #(.W(W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .divRatio (divRatio),
    .modeSel  (balancedMode),
    .count    (count),
    .divClk   (divClk),
    .strobe   (strobe),
    .tapIdx   (tapIdx)
  );

  clkdiv_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .tapIdx   (tapIdx),
    .count    (count),
    .divClk   (divClk),
    .riseTick (riseTick)
  );

endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] count,
  input logic         divClk,
  input logic         riseTick
);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (count == '0 && !divClk && !riseTick)); // R1

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |-> (count == $past(count) + W'(1))); // R2

  AST_TICK_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    riseTick |-> (divClk && !$past(divClk))); // R7

  AST_RISE_HAS_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(divClk) |-> riseTick); // R7

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    riseTick |=> !riseTick); // R7

endmodule

bind clk_enable_divider clkdiv_checker #(.W(W)) u_chk (.*);

// File: tb/test_clk_enable_divider.sv
module test_clk_enable_divider;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] divRatio = '0;
  logic         balancedMode = 1'b0;
  logic         divClk;
  logic         riseTick;
  logic [W-1:0] count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_enable_divider #(.W(W)) i_clk_enable_divider (
    .clk          (clk),
    .rst          (rst),
    .divRatio     (divRatio),
    .balancedMode (balancedMode),
    .divClk       (divClk),
    .riseTick     (riseTick),
    .count        (count)
  );

  // tap bit per R5 (balanced, odd) or R6 (direct)
  function automatic int tapBit(int n, bit bal);
    int best = 0;
    int bestDev = 1 << 30;
    int msb = 0;
    if (!bal) begin
      for (int i = 0; i < W; i++) if (((n - 1) >> i) & 1) msb = i;
      return msb;
    end
    for (int b = 0; b < W; b++) begin
      int lo = 1 << b;
      if (n > lo && n <= 3 * lo) begin
        int h = ((n < 2 * lo) ? n : 2 * lo) - lo;
        int d = (n > 2 * h) ? n - 2 * h : 2 * h - n;
        if (d < bestDev) begin
          bestDev = d;
          best = b;
        end
      end
    end
    return best;
  endfunction

  task automatic expectAt(input int n, input bit bal, input int k,
                          output int eo, output int ec);
    int p;
    if (n < 2) begin
      eo = 0; ec = 0;
      return;
    end
    p = k % n;
    if (bal && (n % 2 == 0)) begin
      ec = p % (n / 2);
      eo = (p >= n / 2) ? 1 : 0;
    end else begin
      ec = p;
      eo = (p >> tapBit(n, bal)) & 1;
    end
  endtask

  function automatic string outTag(int n, bit bal);
    if (n < 2) return "R8";
    if (bal && (n % 2 == 0)) return "R3,R4";
    if (bal) return "R3,R5";
    return "R3,R6";
  endfunction

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // run one configuration, optionally switching to another at sample chgK
  task automatic runCase(input int n0, input bit m0, input int n1, input bit m1,
                         input int chgK, input int total);
    int boundary = -1;
    int prevO = 0;
    int eo, ec, et, n, cn;
    bit m;
    int ticksSeen = 0;
    int ticksExp = 0;
    string tag;
    @(negedge clk);
    rst = 1'b1;
    divRatio = W'(n0);
    balancedMode = m0;
    repeat (2) @(negedge clk);
    check("R1", int'(count), 0, "reset count");
    check("R1", int'(divClk), 0, "reset level");
    check("R1", int'(riseTick), 0, "reset tick");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < total; k++) begin
      if (boundary >= 0 && k >= boundary) begin
        n = n1; m = m1; cn = k - boundary;
      end else begin
        n = n0; m = m0; cn = k;
      end
      expectAt(n, m, cn, eo, ec);
      et = (eo == 1 && prevO == 0) ? 1 : 0;
      prevO = eo;
      ticksExp += et;
      ticksSeen += int'(riseTick);
      tag = (boundary >= 0) ? {"R9,", outTag(n, m)} : outTag(n, m);
      if (n >= 2) check(tag == "R8" ? "R2" : {tag, ",R2"}, int'(count), ec, "count");
      else check(tag, int'(count), ec, "count");
      check(tag, int'(divClk), eo, "level");
      check(n < 2 ? "R8" : "R7", int'(riseTick), et, "tick");
      if (k == chgK) begin
        divRatio = W'(n1);
        balancedMode = m1;
        boundary = (n0 < 2) ? chgK + 1 : ((chgK / n0) + 1) * n0;
      end
      @(negedge clk);
    end
    check("R3", ticksSeen, ticksExp, "rising edges in window");
  endtask

  initial begin
    for (int n = 0; n <= 20; n++) begin
      for (int m = 0; m < 2; m++) begin
        runCase(n, bit'(m), n, bit'(m), -1, 3 * n + 8);
      end
    end
    runCase(6, 1'b1, 10, 1'b1, 2, 60);
    runCase(5, 1'b0, 7, 1'b0, 3, 60);
    runCase(9, 1'b1, 0, 1'b1, 4, 40);
    runCase(0, 1'b1, 6, 1'b1, 5, 40);
    runCase(1, 1'b0, 5, 1'b1, 3, 40);
    runCase(7, 1'b1, 8, 1'b0, 10, 60);
    runCase(12, 1'b1, 5, 1'b1, 0, 60);
    runCase(2, 1'b1, 3, 1'b1, 1, 30);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule